// File: doc/BRIEF.md
# Multiplier PLL Control Bank with Kick Handshake

This block is the register-side controller for a group of clock multiplier PLLs, modelled purely in logic. Each PLL has a 32-bit control word. The word stages a multiplier code, a three-bit spread mode, a modulation rate and a modulation depth. None of these staged values reaches the PLL outputs until software sets the kick bit in that word. The kick starts a relock wait. The wait counts reference ticks against a programmable relock count. When it expires, the staged multiplier and mode are applied, the lock flag of that PLL rises and the kick bit clears, all on the same clock edge.

A shared read-only status word reports the lock flag of every PLL. The flags sit at scattered bit positions. While a PLL's kick is pending, any write to its control word is refused, and a one-cycle reject flag reports the refusal. Software is expected to write a new multiplier together with the kick bit, then poll the status word (or the kick bit) until the PLL reports lock.

The register port is a single-cycle strobe interface with no back-pressure. A write is taken on the clock edge where `reg_wr` is high. Read data is a combinational function of `reg_addr`. Register map:
- Address 0: status word.
- Addresses 1 to N_PLL: the control word of PLL 1 to PLL N_PLL.
- Address N_PLL+1: the relock count.
- Any other address: reads 0 and ignores writes.

Top module: `pllk_ctrl`

## Requirements
- R1: After reset, every PLL reports lock, every control word reads 0 (kick clear, code 0, mode 0), every ratio output is 2, every mode output is 0, and the relock register reads its reset parameter value.
- R2: A write without bit 31 to a control word that is not busy stages the fields: multiplier code in bits 27:20, mode in bits 18:16, modulation rate in bits 14:8 and modulation depth in bits 6:0. Those fields read back, all other bits read 0, and the PLL outputs do not change.
- R3: A write with bit 31 set to a control word that is not busy clears that PLL's lock flag in the following cycle, and bit 31 of that word then reads 1.
- R4: With relock count C captured at the kick, the update completes on the edge of the (C+1)-th cycle with `ref_tick` high after the kick write. On that edge the ratio and mode outputs take the staged values, lock sets and bit 31 clears.
- R5: The ratio output equals 2*(code+1), so it spans 2 (code 0) to 512 (code 255).
- R6: In the status word, the lock flag of PLL n is at bit 7+n for n<3, at bit 11 for n=3 and at bit 9+n for n>3. All other status bits read 0.
- R7: A write to a control word whose kick is pending is refused whole: the word reads back unchanged. `wr_reject` is high for exactly the one cycle after the refused write and is low after accepted writes.
- R8: The relock register is writable and readable at address N_PLL+1. A kick captures its value, so changing it while an update is pending does not alter that update's length.
- R9: A kick on one PLL leaves the lock flag, ratio and mode outputs of every other PLL unchanged.
- R10: The mode output changes only when an update completes and then takes the staged mode field.
- R11: Writes to the status address or to an unmapped address change nothing, and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe |
| reg_addr | input | ADDR_W | Register address for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| ref_tick | input | 1 | Reference tick that advances relock timers |
| wr_reject | output | 1 | One-cycle flag for a refused control-word write |
| pll_locked | output | N_PLL | Lock flag per PLL, bit i for PLL i+1 |
| pll_ratio | output | N_PLL*10 | Applied output/reference ratio per PLL, 10 bits each |
| pll_mode | output | N_PLL*3 | Applied spread mode per PLL, 3 bits each |

## Verification
The hardest case to reach from the ports is a write that lands while an update is still pending, because the relock wait normally expires before software could react. The bench reaches it in two steps. It programs a long relock count and withholds `ref_tick` entirely. It then issues the conflicting write, lowers the relock count to zero, and only afterwards releases the ticks. It counts them one by one to confirm that the completion edge still follows the count captured at the kick.

// File: rtl/pllk_pkg.sv
package pllk_pkg;

  localparam int WORD_W   = 32;
  localparam int KICK_BIT = 31;
  localparam int MULT_LSB = 20;
  localparam int MULT_W   = 8;
  localparam int MODE_LSB = 16;
  localparam int MODE_W   = 3;
  localparam int SSF_LSB  = 8;
  localparam int SSF_W    = 7;
  localparam int SSD_LSB  = 0;
  localparam int SSD_W    = 7;
  localparam int RATIO_W  = MULT_W + 2;

  typedef struct packed {
    logic [MULT_W-1:0] mult;
    logic [MODE_W-1:0] mode;
    logic [SSF_W-1:0]  ssf;
    logic [SSD_W-1:0]  ssd;
  } pll_cfg_t;

  // position of the lock flag of PLL n (n counts from 1) in the status word
  function automatic int lock_pos(input int n);
    if (n < 3)       return 8 + n - 1;
    else if (n == 3) return 11;
    else             return 8 + n + 1;
  endfunction

  function automatic logic [WORD_W-1:0] pack_cfg(input pll_cfg_t c, input logic kick);
    logic [WORD_W-1:0] w;
    w = '0;
    w[KICK_BIT]               = kick;
    w[MULT_LSB +: MULT_W]     = c.mult;
    w[MODE_LSB +: MODE_W]     = c.mode;
    w[SSF_LSB  +: SSF_W]      = c.ssf;
    w[SSD_LSB  +: SSD_W]      = c.ssd;
    return w;
  endfunction

  function automatic pll_cfg_t unpack_cfg(input logic [WORD_W-1:0] w);
    pll_cfg_t c;
    c.mult = w[MULT_LSB +: MULT_W];
    c.mode = w[MODE_LSB +: MODE_W];
    c.ssf  = w[SSF_LSB  +: SSF_W];
    c.ssd  = w[SSD_LSB  +: SSD_W];
    return c;
  endfunction

endpackage

// File: rtl/pllk_relock_timer.sv
module pllk_relock_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  output logic             busy,
  output logic             done
);

  logic [CNT_W-1:0] remain;

  // the wait ends on the tick seen while the remaining count is zero
  assign done = busy & tick & (remain == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      remain <= '0;
    end else if (start) begin
      busy   <= 1'b1;
      remain <= load_val;
    end else if (busy && tick) begin
      if (remain == '0) busy <= 1'b0;
      else              remain <= remain - 1'b1;
    end
  end

endmodule

// File: rtl/pllk_channel.sv
module pllk_channel
  import pllk_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_hit,
  input  logic [WORD_W-1:0]  wdata,
  input  logic               ref_tick,
  input  logic [CNT_W-1:0]   relock_val,
  output logic [WORD_W-1:0]  ctrl_word,
  output logic               kick,
  output logic               locked,
  output logic [RATIO_W-1:0] ratio,
  output logic [MODE_W-1:0]  mode_out,
  output logic               reject
);

  pll_cfg_t          staged;
  pll_cfg_t          applied;
  logic              accept;
  logic              start;
  logic              done;
  logic [MULT_W:0]   mult_p1;

  assign reject = wr_hit & kick;
  assign accept = wr_hit & ~kick;
  assign start  = accept & wdata[KICK_BIT];

  pllk_relock_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .load_val (relock_val),
    .tick     (ref_tick),
    .busy     (kick),
    .done     (done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      staged  <= '0;
      applied <= '0;
      locked  <= 1'b1;
    end else begin
      if (accept) staged <= unpack_cfg(wdata);
      if (start) begin
        locked <= 1'b0;
      end else if (done) begin
        locked  <= 1'b1;
        applied <= staged;
      end
    end
  end

  assign mult_p1   = {1'b0, applied.mult} + {{MULT_W{1'b0}}, 1'b1};
  assign ratio     = {mult_p1, 1'b0};
  assign mode_out  = applied.mode;
  assign ctrl_word = pack_cfg(staged, kick);

endmodule

// File: rtl/pllk_status_map.sv
module pllk_status_map
  import pllk_pkg::*;
#(
  parameter int N_PLL = 6
) (
  input  logic [N_PLL-1:0]  lock_vec,
  output logic [WORD_W-1:0] status_word
);

  always_comb begin
    status_word = '0;
    for (int i = 0; i < N_PLL; i++) begin
      status_word[lock_pos(i + 1)] = lock_vec[i];
    end
  end

endmodule

// File: rtl/pllk_ctrl.sv
module pllk_ctrl
  import pllk_pkg::*;
#(
  parameter int N_PLL        = 6,
  parameter int CNT_W        = 16,
  parameter int ADDR_W       = 4,
  parameter int RELOCK_RESET = 45
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     reg_wr,
  input  logic [ADDR_W-1:0]        reg_addr,
  input  logic [31:0]              reg_wdata,
  output logic [31:0]              reg_rdata,
  input  logic                     ref_tick,
  output logic                     wr_reject,
  output logic [N_PLL-1:0]         pll_locked,
  output logic [N_PLL*RATIO_W-1:0] pll_ratio,
  output logic [N_PLL*MODE_W-1:0]  pll_mode
);

  localparam int RELOCK_ADDR = N_PLL + 1;

  initial begin
    if (N_PLL < 1 || N_PLL > 22) $error("N_PLL must lie in 1..22");
    if ((1 << ADDR_W) <= RELOCK_ADDR) $error("ADDR_W too narrow for the map");
    if (CNT_W > WORD_W) $error("CNT_W wider than a register word");
  end

  logic [WORD_W-1:0] ctrl_words [N_PLL];
  logic [N_PLL-1:0]  wr_hit;
  logic [N_PLL-1:0]  rej_vec;
  logic [N_PLL-1:0]  kick_vec;
  logic [CNT_W-1:0]  relock_q;
  logic [WORD_W-1:0] status_word;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      relock_q  <= CNT_W'(RELOCK_RESET);
      wr_reject <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == ADDR_W'(RELOCK_ADDR)) relock_q <= reg_wdata[CNT_W-1:0];
      wr_reject <= |rej_vec;
    end
  end

  for (genvar g = 0; g < N_PLL; g++) begin : g_pll
    assign wr_hit[g] = reg_wr && (reg_addr == ADDR_W'(g + 1));

    pllk_channel #(.CNT_W(CNT_W)) u_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_hit     (wr_hit[g]),
      .wdata      (reg_wdata),
      .ref_tick   (ref_tick),
      .relock_val (relock_q),
      .ctrl_word  (ctrl_words[g]),
      .kick       (kick_vec[g]),
      .locked     (pll_locked[g]),
      .ratio      (pll_ratio[g*RATIO_W +: RATIO_W]),
      .mode_out   (pll_mode[g*MODE_W +: MODE_W]),
      .reject     (rej_vec[g])
    );
  end

  pllk_status_map #(.N_PLL(N_PLL)) u_status (
    .lock_vec    (pll_locked),
    .status_word (status_word)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == '0) reg_rdata = status_word;
    if (reg_addr == ADDR_W'(RELOCK_ADDR)) reg_rdata = {{(WORD_W-CNT_W){1'b0}}, relock_q};
    for (int i = 0; i < N_PLL; i++) begin
      if (reg_addr == ADDR_W'(i + 1)) reg_rdata = ctrl_words[i];
    end
  end

endmodule

// File: rtl/pllk_ctrl_chk.sv
module pllk_ctrl_chk #(
  parameter int N_PLL   = 6,
  parameter int ADDR_W  = 4,
  parameter int RATIO_W = 10,
  parameter int MODE_W  = 3
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     reg_wr,
  input logic [ADDR_W-1:0]        reg_addr,
  input logic [31:0]              reg_wdata,
  input logic                     ref_tick,
  input logic                     wr_reject,
  input logic [N_PLL-1:0]         pll_locked,
  input logic [N_PLL*RATIO_W-1:0] pll_ratio,
  input logic [N_PLL*MODE_W-1:0]  pll_mode,
  input logic [N_PLL-1:0]         kick_vec
);

  // R7
  reject_has_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_reject |-> $past(reg_wr));

  for (genvar g = 0; g < N_PLL; g++) begin : g_chk
    // R3
    kick_drops_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == ADDR_W'(g + 1) && reg_wdata[31] && !kick_vec[g])
      |=> (!pll_locked[g] && kick_vec[g]));

    // R4
    finish_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(kick_vec[g]) |-> (pll_locked[g] && $past(ref_tick)));

    // R5
    ratio_moves_at_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(pll_ratio[g*RATIO_W +: RATIO_W]) |-> $rose(pll_locked[g]));

    // R10
    mode_moves_at_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(pll_mode[g*MODE_W +: MODE_W]) |-> $rose(pll_locked[g]));

    // R7
    busy_write_rejected_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == ADDR_W'(g + 1) && kick_vec[g]) |=> wr_reject);

    // R3
    lock_kick_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(pll_locked[g] && kick_vec[g]));
  end

endmodule

bind pllk_ctrl pllk_ctrl_chk #(
  .N_PLL   (N_PLL),
  .ADDR_W  (ADDR_W),
  .RATIO_W (pllk_pkg::RATIO_W),
  .MODE_W  (pllk_pkg::MODE_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_wr     (reg_wr),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .ref_tick   (ref_tick),
  .wr_reject  (wr_reject),
  .pll_locked (pll_locked),
  .pll_ratio  (pll_ratio),
  .pll_mode   (pll_mode),
  .kick_vec   (kick_vec)
);

// File: tb/pllk_ctrl_tb.sv
module pllk_ctrl_tb;

  localparam int N      = 6;
  localparam int AW     = 4;
  localparam int RST_RL = 45;
  localparam logic [31:0] KICK = 32'h8000_0000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          ref_tick = 1'b0;
  logic          wr_reject;
  logic [N-1:0]  pll_locked;
  logic [N*10-1:0] pll_ratio;
  logic [N*3-1:0]  pll_mode;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  pllk_ctrl #(.N_PLL(N), .CNT_W(16), .ADDR_W(AW), .RELOCK_RESET(RST_RL)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ref_tick(ref_tick),
    .wr_reject(wr_reject), .pll_locked(pll_locked), .pll_ratio(pll_ratio),
    .pll_mode(pll_mode)
  );

  function automatic int bitpos(input int n);
    if (n == 1) return 8;
    if (n == 2) return 9;
    if (n == 3) return 11;
    return n + 9;
  endfunction

  function automatic logic [31:0] full_mask();
    logic [31:0] m = '0;
    for (int n = 1; n <= N; n++) m[bitpos(n)] = 1'b1;
    return m;
  endfunction

  function automatic logic [9:0] ratio_of(input int n);
    return pll_ratio[(n-1)*10 +: 10];
  endfunction

  function automatic logic [2:0] mode_of(input int n);
    return pll_mode[(n-1)*3 +: 3];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = AW'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    reg_addr = AW'(a);
    #1;
    d = reg_rdata;
  endtask

  task automatic ticks(input int k);
    for (int i = 0; i < k; i++) begin
      @(negedge clk); ref_tick = 1'b1;
      @(negedge clk); ref_tick = 1'b0;
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 locks", 32'(pll_locked), 32'h3F);
    for (int n = 1; n <= N; n++) begin
      rd(n, d);  check("R1 ctrl word", d, 32'h0);
      check("R1 ratio", 32'(ratio_of(n)), 32'd2);
      check("R1 mode", 32'(mode_of(n)), 32'd0);
    end
    rd(N + 1, d); check("R1 relock", d, 32'(RST_RL));
    rd(0, d);     check("R6 status mask", d, full_mask());
  endtask

  task automatic t_stage();
    logic [31:0] d;
    wr(2, 32'h7FFF_FFFF);
    check("R7 no reject on accept", 32'(wr_reject), 32'd0);
    rd(2, d); check("R2 fields only", d, 32'h0FF7_7F7F);
    check("R2 ratio kept", 32'(ratio_of(2)), 32'd2);
    check("R2 lock kept", 32'(pll_locked[1]), 32'd1);
    check("R10 mode kept", 32'(mode_of(2)), 32'd0);
    wr(2, 32'h03C5_552A);
    rd(2, d); check("R2 pattern2", d, 32'h03C5_552A);
  endtask

  task automatic t_kick_timing();
    logic [31:0] d;
    wr(N + 1, 32'd3);
    wr(2, KICK | 32'h03C5_0000);
    check("R3 lock drop", 32'(pll_locked[1]), 32'd0);
    rd(2, d); check("R3 kick reads 1", d, 32'h83C5_0000);
    rd(0, d); check("R6 bit9 clear", d, full_mask() & ~(32'd1 << 9));
    check("R9 others locked", 32'(pll_locked), 32'h3D);
    ticks(3);
    check("R4 still pending", 32'(pll_locked[1]), 32'd0);
    check("R4 ratio held", 32'(ratio_of(2)), 32'd2);
    check("R10 mode held", 32'(mode_of(2)), 32'd0);
    ticks(1);
    check("R4 locked", 32'(pll_locked[1]), 32'd1);
    check("R5 ratio 122", 32'(ratio_of(2)), 32'd122);
    check("R10 mode 5", 32'(mode_of(2)), 32'd5);
    rd(2, d); check("R4 kick cleared", d, 32'h03C5_0000);
  endtask

  task automatic t_refuse();
    logic [31:0] d;
    wr(N + 1, 32'd20);
    wr(4, KICK | 32'h0090_0000);
    wr(4, 32'h0FF7_0000);
    check("R7 reject pulse", 32'(wr_reject), 32'd1);
    rd(4, d); check("R7 word unchanged", d, 32'h8090_0000);
    @(negedge clk);
    check("R7 reject one cycle", 32'(wr_reject), 32'd0);
    check("R9 others locked", 32'(pll_locked), 32'h37);
    check("R9 other ratio", 32'(ratio_of(2)), 32'd122);
    wr(N + 1, 32'd0);
    ticks(20);
    check("R8 captured count", 32'(pll_locked[3]), 32'd0);
    ticks(1);
    check("R8 done", 32'(pll_locked[3]), 32'd1);
    check("R5 ratio 20", 32'(ratio_of(4)), 32'd20);
  endtask

  task automatic t_extremes();
    wr(6, KICK | 32'h0FF0_0000);
    ticks(1);
    check("R5 ratio 512", 32'(ratio_of(6)), 32'd512);
    wr(6, KICK);
    ticks(1);
    check("R5 ratio 2", 32'(ratio_of(6)), 32'd2);
  endtask

  task automatic t_status_map();
    logic [31:0] d;
    wr(N + 1, 32'd45);
    for (int n = 1; n <= N; n++) begin
      wr(n, KICK | (32'(n) << 20));
      rd(0, d); check("R6 position", d, full_mask() & ~(32'd1 << bitpos(n)));
      ticks(46);
      rd(0, d); check("R6 restored", d, full_mask());
      check("R5 ratio", 32'(ratio_of(n)), 32'(2 * (n + 1)));
    end
  endtask

  task automatic t_ignored();
    logic [31:0] d;
    wr(0, 32'h0);
    rd(0, d); check("R11 status write ignored", d, full_mask());
    wr(9, 32'hFFFF_FFFF);
    rd(9, d); check("R11 unmapped reads 0", d, 32'h0);
    check("R11 locks intact", 32'(pll_locked), 32'h3F);
    check("R11 ratio intact", 32'(ratio_of(1)), 32'd4);
    rd(N + 1, d); check("R8 relock readback", d, 32'd45);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_stage();
        t_kick_timing();
        t_refuse();
        t_extremes();
        t_status_map();
        t_ignored();
      end
      begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule